// File: doc/BRIEF.md
# Two-Section Selectable-Modulus Counter

This block is a four-bit counter made of two parts that advance on separate strobes. The low part is a single toggle bit. The high part is a three-bit counter that counts modulo 5, 6 or 8. All logic runs on one system clock. A single-cycle strobe for each part plays the role of a falling clock edge on that part.

A link select joins the two parts inside the block. The low bit's falling transition can drive the high part, which gives decade counting or a binary count to sixteen. The high part's top bit falling can drive the low bit instead, which gives a square wave on the low bit at one tenth of the strobe rate. Either link advances the driven part one cycle after the falling transition, as a ripple chain would.

A two-input gated clear sets the count to zero. A two-input gated preset, present only when `HAS_PRESET` is set, forces the count to nine. When both are asserted together, the preset wins.

Top module: `split_mod_counter`

## Requirements
- R1: After `rstN` is released, `cntQ` reads 0000.
- R2: With `linkSel` not 2'b10, each `stepLo` strobe inverts `cntQ[0]` and leaves `cntQ[3:1]` unchanged. In any cycle with no strobe, clear or preset, `cntQ[0]` holds its value.
- R3: In modulo-8 mode (`modeSel` 2'b10 or 2'b11), each high-part advance adds one to `cntQ[3:1]`, and 7 wraps to 0.
- R4: In modulo-5 mode (`modeSel` 2'b00), `cntQ[3:1]` steps 0,1,2,3,4 and then wraps to 0. It never exceeds 4.
- R5: In modulo-6 mode (`modeSel` 2'b01), `cntQ[3:1]` steps 000, 001, 010, 100, 101, 110 and then returns to 000. The values 011 and 111 never appear.
- R6: When `clrA` and `clrB` are both high, `cntQ` becomes 0000 on the next edge, whatever the strobes are doing. Either input alone has no effect.
- R7: With `HAS_PRESET`=1, when `setA` and `setB` are both high, `cntQ` becomes 1001 on the next edge, even if clear is also active. Either input alone has no effect.
- R8: `modeSel` is captured only on edges where the gated clear is active. A change to `modeSel` at any other time does not alter the counting modulus.
- R9: With `linkSel`=2'b01, the high part advances exactly once, one cycle after `cntQ[0]` falls, and `stepHi` is ignored. In modulo-5 mode this gives a binary-coded decimal count 0 to 9 that wraps to 0. In modulo-8 mode it gives a binary count 0 to 15.
- R10: With `linkSel`=2'b10, the low bit toggles one cycle after `cntQ[3]` falls, and `stepLo` is ignored. In modulo-5 mode, `cntQ[0]` then changes once every five `stepHi` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; clears the count and sets modulo 8 |
| modeSel | input | 2 | High-part modulus: 00 = 5, 01 = 6, 10/11 = 8; captured during clear |
| linkSel | input | 2 | 00/11 = separate, 01 = low bit drives high part, 10 = top bit drives low bit |
| stepLo | input | 1 | Advance strobe for the low bit |
| stepHi | input | 1 | Advance strobe for the high part |
| clrA | input | 1 | Clear gate input one |
| clrB | input | 1 | Clear gate input two |
| setA | input | 1 | Preset-to-nine gate input one |
| setB | input | 1 | Preset-to-nine gate input two |
| cntQ | output | 4 | Count value; bit 0 is the low bit, bits 3:1 are the high part |

## Verification
The gated clear and the gated preset can land in the same cycle. The bench raises all four gate inputs together and expects 1001 on the next edge. A count strobe can also coincide with the gated clear: the bench pulses `stepLo` while both clear inputs are high and expects 0000. This shows that the override takes effect before the toggle. Single gate inputs are pulsed alone, and the bench confirms that the count read at the port does not change.

// File: rtl/split_mod_pkg.sv
package split_mod_pkg;
  localparam int HI_W = 3;
  localparam int Q_W  = HI_W + 1;

  typedef enum logic [1:0] {
    MODE_DIV5 = 2'b00,
    MODE_DIV6 = 2'b01,
    MODE_DIV8 = 2'b10
  } hiMode_e;

  typedef enum logic [1:0] {
    LINK_NONE  = 2'b00,
    LINK_LO2HI = 2'b01,
    LINK_HI2LO = 2'b10
  } link_e;

  typedef struct packed {
    logic advLo;
    logic advHi;
    logic clear;
    logic preset;
  } strobe_t;

  localparam logic [Q_W-1:0] PRESET_VAL = Q_W'(9);
endpackage

// File: rtl/split_mod_ctrl.sv
module split_mod_ctrl
  import split_mod_pkg::*;
#(
  parameter bit HAS_PRESET = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     linkSel,
  input  logic           stepLo,
  input  logic           stepHi,
  input  logic           clrA,
  input  logic           clrB,
  input  logic           setA,
  input  logic           setB,
  input  logic [Q_W-1:0] cntQ,
  output strobe_t        strb
);
  logic q0Prev;
  logic q3Prev;
  logic fallLo;
  logic fallHi;
  logic clearReq;
  logic presetReq;

  generate
    if (HAS_PRESET) begin : gPreset
      assign presetReq = setA & setB;
    end else begin : gNoPreset
      logic unusedSet;
      assign unusedSet = setA ^ setB;
      assign presetReq = 1'b0;
    end
  endgenerate

  assign clearReq = clrA & clrB;
  assign fallLo   = q0Prev & ~cntQ[0];
  assign fallHi   = q3Prev & ~cntQ[Q_W-1];

  always_comb begin
    strb.preset = presetReq;
    strb.clear  = clearReq;
    strb.advLo  = (linkSel == LINK_HI2LO) ? fallHi : stepLo;
    strb.advHi  = (linkSel == LINK_LO2HI) ? fallLo : stepHi;
  end

  // Edge history follows forced values so a clear or preset never looks like a fall.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q0Prev <= 1'b0;
      q3Prev <= 1'b0;
    end else if (presetReq) begin
      q0Prev <= PRESET_VAL[0];
      q3Prev <= PRESET_VAL[Q_W-1];
    end else if (clearReq) begin
      q0Prev <= 1'b0;
      q3Prev <= 1'b0;
    end else begin
      q0Prev <= cntQ[0];
      q3Prev <= cntQ[Q_W-1];
    end
  end

  // R9
  lo_fall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallLo |=> !fallLo);

  // R10
  hi_fall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallHi |=> !fallHi);
endmodule

// File: rtl/split_mod_path.sv
module split_mod_path
  import split_mod_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     modeSel,
  input  strobe_t        strb,
  output logic [Q_W-1:0] cntQ
);
  logic            loBit;
  logic [HI_W-1:0] hiCnt;
  logic [HI_W-1:0] hiNext;
  hiMode_e         modeReg;
  hiMode_e         modeIn;

  always_comb begin
    case (modeSel)
      2'b00:   modeIn = MODE_DIV5;
      2'b01:   modeIn = MODE_DIV6;
      default: modeIn = MODE_DIV8;
    endcase
  end

  always_comb begin
    case (modeReg)
      MODE_DIV5: hiNext = (hiCnt >= HI_W'(4)) ? '0 : hiCnt + HI_W'(1);
      MODE_DIV6: begin
        case (hiCnt)
          HI_W'(0): hiNext = HI_W'(1);
          HI_W'(1): hiNext = HI_W'(2);
          HI_W'(2): hiNext = HI_W'(4);
          HI_W'(4): hiNext = HI_W'(5);
          HI_W'(5): hiNext = HI_W'(6);
          default:  hiNext = '0;
        endcase
      end
      default:   hiNext = hiCnt + HI_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loBit <= 1'b0;
      hiCnt <= '0;
    end else if (strb.preset) begin
      loBit <= PRESET_VAL[0];
      hiCnt <= PRESET_VAL[Q_W-1:1];
    end else if (strb.clear) begin
      loBit <= 1'b0;
      hiCnt <= '0;
    end else begin
      if (strb.advLo) loBit <= ~loBit;
      if (strb.advHi) hiCnt <= hiNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeReg <= MODE_DIV8;
    else if (strb.clear) modeReg <= modeIn;
  end

  assign cntQ = {hiCnt, loBit};

  // R7
  preset_nine_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.preset |=> cntQ == PRESET_VAL);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !strb.preset) |=> cntQ == '0);

  // R2
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.advLo || strb.clear || strb.preset) |=> $stable(loBit));

  // R4
  div5_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_DIV5) |-> hiCnt <= HI_W'(4));

  // R5
  div6_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_DIV6) |-> (hiCnt != HI_W'(3) && hiCnt != HI_W'(7)));
endmodule

// File: rtl/split_mod_counter.sv
module split_mod_counter
  import split_mod_pkg::*;
#(
  parameter bit HAS_PRESET = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     modeSel,
  input  logic [1:0]     linkSel,
  input  logic           stepLo,
  input  logic           stepHi,
  input  logic           clrA,
  input  logic           clrB,
  input  logic           setA,
  input  logic           setB,
  output logic [Q_W-1:0] cntQ
);
  strobe_t strb;

  split_mod_ctrl #(.HAS_PRESET(HAS_PRESET)) ctrl_i (
    .clk(clk), .rstN(rstN), .linkSel(linkSel),
    .stepLo(stepLo), .stepHi(stepHi),
    .clrA(clrA), .clrB(clrB), .setA(setA), .setB(setB),
    .cntQ(cntQ), .strb(strb)
  );

  split_mod_path path_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .strb(strb), .cntQ(cntQ)
  );
endmodule

// File: tb/split_mod_counter_tb_top.sv
module split_mod_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b10;
  logic [1:0] linkSel = 2'b00;
  logic       stepLo = 1'b0, stepHi = 1'b0;
  logic       clrA = 1'b0, clrB = 1'b0, setA = 1'b0, setB = 1'b0;
  logic [3:0] cntQ;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] val;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  split_mod_counter dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .linkSel(linkSel),
    .stepLo(stepLo), .stepHi(stepHi), .clrA(clrA), .clrB(clrB),
    .setA(setA), .setB(setB), .cntQ(cntQ)
  );

  // monitor: pops expectations and compares at falling clock edges
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (cntQ !== e.val) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", e.tag, cntQ, e.val);
        end
      end
    end
  end

  task automatic expectQ(input logic [3:0] v, input string tag);
    repeat (3) @(negedge clk);
    expQ.push_back('{val: v, tag: tag});
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input bit lo, input bit hi);
    @(negedge clk);
    stepLo = lo; stepHi = hi;
    @(negedge clk);
    stepLo = 1'b0; stepHi = 1'b0;
  endtask

  task automatic gates(input bit ca, input bit cb, input bit sa, input bit sb, input bit lo);
    @(negedge clk);
    clrA = ca; clrB = cb; setA = sa; setB = sb; stepLo = lo;
    @(negedge clk);
    clrA = 1'b0; clrB = 1'b0; setA = 1'b0; setB = 1'b0; stepLo = 1'b0;
  endtask

  task automatic masterClear(input logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    gates(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq6 [6];
    seq6 = '{3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b000};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectQ(4'b0000, "R1 reset value");

    // separate sections, modulo 8
    masterClear(2'b10);
    pulse(1, 0);
    expectQ(4'b0001, "R2 low toggle");
    pulse(0, 1);
    expectQ(4'b0011, "R2 high moves, low kept");
    for (int i = 0; i < 7; i++) pulse(0, 1);
    expectQ(4'b0001, "R3 mod8 wrap 7->0");
    pulse(1, 0);
    expectQ(4'b0000, "R2 second toggle");
    pulse(1, 0);

    // single clear input, then clear against strobe
    gates(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expectQ(4'b0001, "R6 single clear input ignored");
    gates(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    expectQ(4'b0000, "R6 clear overrides strobe");

    // mode change without clear is not captured
    @(negedge clk); modeSel = 2'b00;
    for (int i = 0; i < 5; i++) pulse(0, 1);
    expectQ(4'b1010, "R8 mode held at mod8");

    // modulo 5
    masterClear(2'b00);
    expectQ(4'b0000, "R8 clear with new mode");
    for (int i = 0; i < 4; i++) pulse(0, 1);
    expectQ(4'b1000, "R4 mod5 reaches 4");
    pulse(0, 1);
    expectQ(4'b0000, "R4 mod5 wrap 4->0");

    // modulo 6 sequence
    masterClear(2'b01);
    for (int i = 0; i < 6; i++) begin
      pulse(0, 1);
      expectQ({seq6[i], 1'b0}, $sformatf("R5 mod6 step %0d", i + 1));
    end

    // preset
    gates(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expectQ(4'b0000, "R7 single set input ignored");
    @(negedge clk); modeSel = 2'b00;
    gates(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    expectQ(4'b1001, "R7 preset beats clear");

    // decade chain: nine rolls to zero
    @(negedge clk); linkSel = 2'b01;
    pulse(1, 0);
    expectQ(4'b0000, "R9 nine rolls to zero");
    for (int n = 1; n <= 12; n++) begin
      pulse(1, 0);
      expectQ(4'(n % 10), $sformatf("R9 decade count %0d", n));
    end
    pulse(0, 1);
    expectQ(4'(2), "R9 high strobe ignored when linked");

    // binary chain to sixteen
    masterClear(2'b10);
    for (int n = 1; n <= 17; n++) begin
      pulse(1, 0);
      if (n % 4 == 0 || n >= 14)
        expectQ(4'(n % 16), $sformatf("R9 binary count %0d", n));
    end

    // top bit drives low bit: divide by ten on bit 0
    @(negedge clk); linkSel = 2'b10;
    masterClear(2'b00);
    for (int c = 1; c <= 20; c++) begin
      pulse(0, 1);
      expectQ({3'(c % 5), 1'((c / 5) % 2)}, $sformatf("R10 reverse link step %0d", c));
    end
    pulse(0, 1);
    pulse(1, 0);
    expectQ(4'b0010, "R10 low strobe ignored when linked");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule